// File: doc/BRIEF.md
# Zero-Crossing Gated Level Controller

This block sits in a six-channel audio output path and decides when a newly requested attenuation level and mute bit may replace the setting a channel is currently using. Software-side writes land in a per-channel holding slot. The slot moves into the active setting only at a point where that channel's own sample stream passes through zero. This keeps level steps from producing audible clicks. If the stream never crosses zero, a frame-count timeout forces the change.

Each channel has its own crossing detector, its own timeout counter and its own acceptance flag. The flag is high while a written value waits and low once the value is active. A global bypass control makes writes take effect at once. The attenuation arithmetic is done downstream; this block only outputs the active level and mute per channel.

Top module: `zc_level_ctrl`

## Requirements
- R1: After synchronous reset every channel reports active level 0, mute 0 and acceptance flag 0.
- R2: A write with bypass low raises that channel's acceptance flag in the next cycle. The channel's active level and mute keep their old values until the change is applied.
- R3: A pending channel applies its held level and mute at the clock edge of a frame strobe whose sample sign bit (MSB, two's complement) differs from the sign of that channel's previous strobed sample. The acceptance flag drops at the same edge.
- R4: A strobed sample equal to zero counts as a crossing, whatever the previous sign was.
- R5: With no crossing, a pending change is applied one cycle after the 512th frame strobe that follows the write, and not before. The counter is 10 bits and forces the change when bit 9 is set.
- R6: With bypass high, a write becomes active in the next cycle and the acceptance flag stays low. Raising bypass while a change is pending applies it in the next cycle.
- R7: A second write to a pending channel replaces the held level and mute and restarts that channel's timeout from zero.
- R8: Channels are independent: a write to, or a crossing on, one channel never changes another channel's active setting or flag.
- R9: Samples are looked at only on frame strobe cycles. The previous-sign memory of each channel starts as positive after reset. Channel index is wr_chan, 0 to 5; sample channel c occupies bits [16c+15:16c].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per audio frame; samples valid with it |
| sample_bus | input | 96 | Six signed 16-bit samples, channel c in bits [16c+15:16c] |
| wr_en | input | 1 | Setting write strobe |
| wr_chan | input | 3 | Channel addressed by the write |
| wr_level | input | 8 | Requested attenuation level |
| wr_mute | input | 1 | Requested mute |
| zc_bypass | input | 1 | When high, settings apply without waiting for a crossing |
| act_level | output | 48 | Active level per channel, channel c in bits [8c+7:8c] |
| act_mute | output | 6 | Active mute per channel |
| accept_pend | output | 6 | High while a channel has a written setting not yet active |

## Verification
A wrong slot state shows as an acceptance flag that stays high or drops on the wrong edge. It also shows as a level that changes between crossings, visible on the cycle after the faulty write or strobe. A wrong sign memory or zero test moves the apply edge by one or more frames, so the bench compares every channel on every cycle against its own model. A timeout counter that is off by one is only visible around 512 frames after a write. For that reason one directed sequence holds a channel's samples positive and checks the flag on both sides of the expected edge.

// File: rtl/zcg_pkg.sv
// Shared types for the zero-crossing gated level controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package zcg_pkg;

    // Holding slot state per channel
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_WAIT = 1'b1
    } slot_state_t;

endpackage

// File: rtl/zcg_cross_detect.sv
// Per-channel zero-crossing detector.
// Flags a crossing on a frame strobe when the sample is zero or its sign
// differs from the previously strobed sample of the same channel.
// Assumes samples are two's complement and valid only with frame_stb.
module zcg_cross_detect #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_stb,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                cross_hit
);

    localparam int unsigned SIGN_BIT = SAMPLE_W - 1;

    logic prev_sign;
    logic is_zero;
    logic sign_flip;

    // Remember the sign of the last strobed sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sign <= 1'b0;
        end else if (frame_stb) begin
            prev_sign <= sample[SIGN_BIT];
        end
    end

    // Combine the zero test and the sign comparison
    always_comb begin
        is_zero   = (sample == '0);
        sign_flip = sample[SIGN_BIT] ^ prev_sign;
        cross_hit = frame_stb & (is_zero | sign_flip);
    end

    AST_PREV_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> prev_sign == $past(sample[SIGN_BIT])); // R9
    AST_NO_HIT_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |-> !cross_hit); // R9

endmodule

// File: rtl/zcg_frame_timer.sv
// Per-channel frame-count timeout.
// Counts frame strobes while its slot is waiting; the top bit of the
// counter marks expiry. Cleared when the slot is rewritten or applied.
// Assumes clr and run come from the holding slot of the same channel.
module zcg_frame_timer #(
    parameter int unsigned TMO_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic run,
    input  logic clr,
    output logic expired
);

    localparam int unsigned        FLAG_BIT = TMO_W - 1;
    localparam logic [TMO_W-1:0]   CAP      = TMO_W'(1) << FLAG_BIT;

    logic [TMO_W-1:0] cnt;

    // Advance on each strobe while waiting, stop once the flag bit is set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && frame_stb && !cnt[FLAG_BIT]) begin
            cnt <= cnt + TMO_W'(1);
        end
    end

    // Expiry is the flag bit of the counter
    always_comb begin
        expired = cnt[FLAG_BIT];
    end

    AST_TMO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP); // R5
    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0); // R7

endmodule

// File: rtl/zcg_setting_slot.sv
// Per-channel holding slot and active setting.
// Takes writes into a held value, marks it waiting, and moves it into the
// active setting on a crossing, a timeout or when bypass is high.
// A write in the same cycle as an apply wins and restarts the wait.
module zcg_setting_slot #(
    parameter int unsigned LEVEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [LEVEL_W-1:0] wr_level,
    input  logic               wr_mute,
    input  logic               bypass,
    input  logic               cross_hit,
    input  logic               tmo_hit,
    output logic [LEVEL_W-1:0] act_level,
    output logic               act_mute,
    output logic               waiting,
    output logic               timer_clr
);

    import zcg_pkg::*;

    slot_state_t        state;
    logic [LEVEL_W-1:0] held_level;
    logic               held_mute;
    logic               apply_now;

    // Decide whether the held value moves to the active setting this cycle
    always_comb begin
        waiting   = (state == SLOT_WAIT);
        apply_now = waiting & (bypass | cross_hit | tmo_hit);
        timer_clr = wr_hit | apply_now;
    end

    // Slot state, held value and active setting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SLOT_IDLE;
            held_level <= '0;
            held_mute  <= 1'b0;
            act_level  <= '0;
            act_mute   <= 1'b0;
        end else if (wr_hit && bypass) begin
            state     <= SLOT_IDLE;
            act_level <= wr_level;
            act_mute  <= wr_mute;
        end else if (wr_hit) begin
            state      <= SLOT_WAIT;
            held_level <= wr_level;
            held_mute  <= wr_mute;
        end else if (apply_now) begin
            state     <= SLOT_IDLE;
            act_level <= held_level;
            act_mute  <= held_mute;
        end
    end

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !bypass) |=> waiting && held_level == $past(wr_level)
                                && $stable(act_level) && $stable(act_mute)); // R2
    AST_CROSS_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && cross_hit && !wr_hit) |=> !waiting
            && act_level == $past(held_level) && act_mute == $past(held_mute)); // R3
    AST_BYPASS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bypass) |=> !waiting && act_level == $past(wr_level)); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting && !wr_hit) |=> $stable(act_level) && $stable(act_mute)); // R8

endmodule

// File: rtl/zc_level_ctrl.sv
// Six-channel zero-crossing gated level controller (top).
// Routes the write to the addressed channel and builds one detector, one
// timer and one holding slot per channel. Writes to an index at or above
// NCH select no channel. Samples are packed, channel c in slice c.
module zc_level_ctrl #(
    parameter int unsigned NCH      = 6,
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned LEVEL_W  = 8,
    parameter int unsigned TMO_W    = 10,
    localparam int unsigned CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_stb,
    input  logic [NCH*SAMPLE_W-1:0] sample_bus,
    input  logic                    wr_en,
    input  logic [CH_W-1:0]         wr_chan,
    input  logic [LEVEL_W-1:0]      wr_level,
    input  logic                    wr_mute,
    input  logic                    zc_bypass,
    output logic [NCH*LEVEL_W-1:0]  act_level,
    output logic [NCH-1:0]          act_mute,
    output logic [NCH-1:0]          accept_pend
);

    logic [NCH-1:0] wr_sel;
    logic [NCH-1:0] cross_hit;
    logic [NCH-1:0] tmo_hit;
    logic [NCH-1:0] timer_clr;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Address decode of the write for this channel
        always_comb begin
            wr_sel[g] = wr_en & (wr_chan == CH_W'(g));
        end

        zcg_cross_detect #(.SAMPLE_W(SAMPLE_W)) i_detect (
            .clk       (clk),
            .rst_n     (rst_n),
            .frame_stb (frame_stb),
            .sample    (sample_bus[g*SAMPLE_W +: SAMPLE_W]),
            .cross_hit (cross_hit[g])
        );

        zcg_frame_timer #(.TMO_W(TMO_W)) i_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .frame_stb (frame_stb),
            .run       (accept_pend[g]),
            .clr       (timer_clr[g]),
            .expired   (tmo_hit[g])
        );

        zcg_setting_slot #(.LEVEL_W(LEVEL_W)) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (wr_sel[g]),
            .wr_level  (wr_level),
            .wr_mute   (wr_mute),
            .bypass    (zc_bypass),
            .cross_hit (cross_hit[g]),
            .tmo_hit   (tmo_hit[g]),
            .act_level (act_level[g*LEVEL_W +: LEVEL_W]),
            .act_mute  (act_mute[g]),
            .waiting   (accept_pend[g]),
            .timer_clr (timer_clr[g])
        );
    end

    AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> accept_pend == '0 && act_mute == '0 && act_level == '0); // R1

endmodule

// File: tb/test_zc_level_ctrl.sv
// Bench for zc_level_ctrl: directed corner cases plus seeded random traffic,
// compared every cycle against a behavioural model built from the requirements.
module test_zc_level_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int SW  = 16;
    localparam int LW  = 8;
    localparam int TMO = 512;
    localparam int WATCHDOG = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_stb = 1'b0;
    logic [NCH*SW-1:0] sample_bus = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_chan = '0;
    logic [LW-1:0]     wr_level = '0;
    logic              wr_mute = 1'b0;
    logic              zc_bypass = 1'b0;
    logic [NCH*LW-1:0] act_level;
    logic [NCH-1:0]    act_mute;
    logic [NCH-1:0]    accept_pend;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    // model state
    logic [LW-1:0] m_lvl [NCH];
    logic          m_mute [NCH];
    logic          m_pend [NCH];
    logic [LW-1:0] m_hlvl [NCH];
    logic          m_hmute [NCH];
    int            m_cnt [NCH];
    logic          m_sign [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    zc_level_ctrl i_zc_level_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sample_bus(sample_bus),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_level(wr_level), .wr_mute(wr_mute),
        .zc_bypass(zc_bypass), .act_level(act_level), .act_mute(act_mute),
        .accept_pend(accept_pend)
    );

    function automatic logic [SW-1:0] smp(input int c);
        return sample_bus[c*SW +: SW];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_lvl[c] = '0; m_mute[c] = 1'b0; m_pend[c] = 1'b0;
            m_hlvl[c] = '0; m_hmute[c] = 1'b0; m_cnt[c] = 0; m_sign[c] = 1'b0;
        end
    endtask

    // one clock edge of the model, using the inputs held across that edge
    task automatic model_step();
        for (int c = 0; c < NCH; c++) begin
            logic [SW-1:0] s;
            logic zc;
            logic apply;
            s = smp(c);
            zc = frame_stb && ((s == '0) || (s[SW-1] != m_sign[c]));
            apply = m_pend[c] && (zc_bypass || zc || m_cnt[c] >= TMO);
            if (frame_stb) m_sign[c] = s[SW-1];
            if (wr_en && int'(wr_chan) == c) begin
                if (zc_bypass) begin
                    m_lvl[c] = wr_level; m_mute[c] = wr_mute; m_pend[c] = 1'b0;
                end else begin
                    m_hlvl[c] = wr_level; m_hmute[c] = wr_mute; m_pend[c] = 1'b1;
                end
                m_cnt[c] = 0;
            end else if (apply) begin
                m_lvl[c] = m_hlvl[c]; m_mute[c] = m_hmute[c]; m_pend[c] = 1'b0;
                m_cnt[c] = 0;
            end else if (m_pend[c] && frame_stb && m_cnt[c] < TMO) begin
                m_cnt[c]++;
            end
        end
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            chk(act_level[c*LW +: LW] == m_lvl[c], $sformatf("%s level ch%0d", tag, c),
                int'(act_level[c*LW +: LW]), int'(m_lvl[c]));
            chk(act_mute[c] == m_mute[c], $sformatf("%s mute ch%0d", tag, c),
                int'(act_mute[c]), int'(m_mute[c]));
            chk(accept_pend[c] == m_pend[c], $sformatf("%s accept ch%0d", tag, c),
                int'(accept_pend[c]), int'(m_pend[c]));
        end
    endtask

    // advance one cycle, update model, compare at the falling edge
    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
        wr_en = 1'b0;
        frame_stb = 1'b0;
    endtask

    task automatic set_sample(input int c, input bit neg, input bit zero);
        logic [SW-1:0] v;
        v = SW'($urandom_range(1, 32767));
        if (neg) v = -v;
        if (zero) v = '0;
        sample_bus[c*SW +: SW] = v;
    endtask

    task automatic all_pos();
        for (int c = 0; c < NCH; c++) set_sample(c, 1'b0, 1'b0);
    endtask

    task automatic do_write(input int c, input int lvl, input bit mu);
        wr_en = 1'b1; wr_chan = 3'(c); wr_level = LW'(lvl); wr_mute = mu;
    endtask

    task automatic pos_frames(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            all_pos(); frame_stb = 1'b1; tick(tag);
        end
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            tests_run++; tests_failed++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0cc1));
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        tick("R1 idle");

        // R2 / R3: write ch0, positive samples keep it pending, then a sign flip
        all_pos();
        do_write(0, 8'h40, 1'b1); tick("R2 write");
        chk(accept_pend[0] == 1'b1, "R2 flag high", int'(accept_pend[0]), 1);
        pos_frames(5, "R2 held");
        chk(act_level[7:0] == 8'h00, "R2 level unchanged", int'(act_level[7:0]), 0);
        set_sample(0, 1'b1, 1'b0); frame_stb = 1'b1; tick("R3 flip");
        chk(act_level[7:0] == 8'h40 && act_mute[0] && !accept_pend[0], "R3 applied",
            int'(act_level[7:0]), 'h40);

        // R8: ch1 and ch2 pending, crossing only on ch1
        all_pos(); tick("R8 settle");
        do_write(1, 8'h11, 1'b0); tick("R8 w1");
        do_write(2, 8'h22, 1'b1); tick("R8 w2");
        all_pos(); set_sample(1, 1'b1, 1'b0); frame_stb = 1'b1; tick("R8 cross ch1");
        chk(accept_pend[2] == 1'b1 && act_level[2*LW +: LW] == 8'h00, "R8 ch2 untouched",
            int'(accept_pend[2]), 1);

        // R9: sign change without strobe is ignored
        set_sample(2, 1'b1, 1'b0); tick("R9 no strobe");
        chk(accept_pend[2] == 1'b1, "R9 ignored off strobe", int'(accept_pend[2]), 1);

        // R4: zero sample on ch2 crosses
        all_pos(); set_sample(2, 1'b0, 1'b1); frame_stb = 1'b1; tick("R4 zero");
        chk(act_level[2*LW +: LW] == 8'h22 && !accept_pend[2], "R4 zero applies",
            int'(act_level[2*LW +: LW]), 'h22);

        // R5: timeout on ch3 with samples held positive
        all_pos(); pos_frames(1, "R5 prime");
        do_write(3, 8'h33, 1'b0); tick("R5 write");
        pos_frames(TMO - 1, "R5 counting");
        chk(accept_pend[3] == 1'b1, "R5 not before 512", int'(accept_pend[3]), 1);
        pos_frames(1, "R5 512th");
        chk(accept_pend[3] == 1'b1, "R5 pending at 512th", int'(accept_pend[3]), 1);
        tick("R5 expire");
        chk(act_level[3*LW +: LW] == 8'h33 && !accept_pend[3], "R5 timeout applies",
            int'(act_level[3*LW +: LW]), 'h33);

        // R7: rewrite restarts the timeout and replaces the value
        do_write(4, 8'h44, 1'b0); tick("R7 first");
        pos_frames(300, "R7 wait a");
        do_write(4, 8'h45, 1'b1); tick("R7 rewrite");
        pos_frames(300, "R7 wait b");
        chk(accept_pend[4] == 1'b1, "R7 restarted", int'(accept_pend[4]), 1);
        pos_frames(TMO - 300, "R7 wait c");
        tick("R7 expire");
        chk(act_level[4*LW +: LW] == 8'h45 && act_mute[4], "R7 new value",
            int'(act_level[4*LW +: LW]), 'h45);

        // R6: bypass makes writes immediate, and releases a pending one
        zc_bypass = 1'b1; do_write(5, 8'h55, 1'b1); tick("R6 direct");
        chk(act_level[5*LW +: LW] == 8'h55 && !accept_pend[5], "R6 direct",
            int'(act_level[5*LW +: LW]), 'h55);
        zc_bypass = 1'b0; do_write(5, 8'h56, 1'b0); tick("R6 pend");
        zc_bypass = 1'b1; tick("R6 release");
        chk(act_level[5*LW +: LW] == 8'h56 && !accept_pend[5], "R6 release",
            int'(act_level[5*LW +: LW]), 'h56);
        zc_bypass = 1'b0;

        // random traffic, some channels biased to one sign to reach timeouts
        for (int i = 0; i < 6000; i++) begin
            frame_stb = ($urandom_range(0, 2) == 0);
            for (int c = 0; c < NCH; c++) begin
                bit neg;
                neg = (c >= 4) ? 1'b0 : ($urandom_range(0, 7) == 0);
                set_sample(c, neg, $urandom_range(0, 63) == 0);
            end
            if ($urandom_range(0, 9) == 0)
                do_write($urandom_range(0, NCH - 1), $urandom_range(0, 255), $urandom_range(0, 1) == 1);
            zc_bypass = ($urandom_range(0, 49) == 0);
            tick("R3/R5/R8 random");
        end
        zc_bypass = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule